// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block is a free-running supervision counter that advances on a low-speed tick, nominally 32.768 kHz, supplied as a one-cycle enable in the system clock domain. Software picks one of four timeout lengths through a small write port. It keeps the system alive by writing a two-byte unlock-and-clear pattern to a key register before the count runs out.

When the counter expires for the first time after a clear, the block raises a one-cycle non-maskable interrupt request. This gives firmware one more full period to recover. If the counter expires a second time with no clear in between, the block raises a reset request. That request stays high until the block itself is reset.

A newly written timeout length is held as pending and is only loaded at the next valid clear. A count already under way can never be cut short by a period change.

Top module: `lsw_watchdog`

## Requirements
- R1: While `rst_n` is low, and right after its synchronised release, `nmi_req` and `rst_req` are low, the counter is zero and the active period select is 0.
- R2: The counter advances only in cycles where `tick_en` is high. Select value s (0..3) sets a timeout of 2^(BASE_LOG2+2*s) ticks after the last clear. With the default BASE_LOG2=12 these are 4096, 16384, 65536 and 262144 ticks, which is 125 ms, 0.5 s, 2 s and 8 s at 32.768 kHz.
- R3: A clear happens only when a key-register write of 0xA5 directly follows a key-register write of 0x5A. Any other key value disarms the detector. A repeated 0x5A keeps it armed. Period-register writes between the two keys do not disarm it.
- R4: A valid clear zeroes the counter on the clock edge of the 0xA5 write and returns the escalation stage to idle, so the next expiry gives an interrupt again.
- R5: The first expiry after a clear or reset drives `nmi_req` high for exactly one cycle, starting on the edge of the expiring tick.
- R6: A second expiry with no clear since the first raises `rst_req` on the edge of the expiring tick, with no interrupt for that expiry.
- R7: Once high, `rst_req` stays high until `rst_n` is asserted. Clears and later expiries neither drop it nor produce interrupts.
- R8: The period select is written through bits [1:0] of the period register. It is loaded into the active select only at the next valid clear.
- R9: Address decode: `wr_addr`=0 selects the period register and `wr_addr`=1 selects the key register. Key values written to the period register never clear the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle low-speed tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: period register, 1: key register |
| wr_data | input | 8 | Write data |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with BASE_LOG2=4, so the four selections give 16, 64, 256 and 1024 ticks. With `tick_en` held high, every selection, both escalation steps and the hold-until-reset behaviour fit in a few thousand cycles. The shortest period also puts the exact expiry edge, relative to the clear edge, within reach for the key-sequence corner cases, the deferred period load and a tick gap.

// File: rtl/lsw_wdt_pkg.sv
package lsw_wdt_pkg;
  typedef enum logic [1:0] {
    STG_IDLE    = 2'd0,
    STG_WARNED  = 2'd1,
    STG_TRIPPED = 2'd2
  } wdt_stage_e;

  localparam logic [7:0] KEY_ARM  = 8'h5A;
  localparam logic [7:0] KEY_FIRE = 8'hA5;

  localparam logic ADDR_PERIOD = 1'b0;
  localparam logic ADDR_KEY    = 1'b1;
endpackage

// File: rtl/lsw_wdt_rstsync.sv
module lsw_wdt_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/lsw_wdt_keyseq.sv
module lsw_wdt_keyseq
  import lsw_wdt_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  output logic             clr_fire
);
  logic armed_q;
  logic armed_d;

  // Unlock byte arms; the next key write fires only if it is the clear byte.
  always_comb begin
    armed_d  = armed_q;
    clr_fire = 1'b0;
    if (key_wr) begin
      clr_fire = armed_q && (key_data == KEY_FIRE);
      armed_d  = (key_data == KEY_ARM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/lsw_wdt_period.sv
module lsw_wdt_period #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_data,
  input  logic             clr_fire,
  output logic [SEL_W-1:0] act_sel
);
  logic [SEL_W-1:0] pend_q, pend_d;
  logic [SEL_W-1:0] act_q,  act_d;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (sel_wr)   pend_d = sel_data;
    if (clr_fire) act_d  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign act_sel = act_q;
endmodule

// File: rtl/lsw_wdt_count.sv
module lsw_wdt_count #(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2,
  localparam int NUM_SEL  = 1 << SEL_W,
  localparam int CNT_W    = BASE_LOG2 + STEP_LOG2 * (NUM_SEL - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             clr_fire,
  input  logic [SEL_W-1:0] act_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic [CNT_W-1:0] term [NUM_SEL];
  logic [CNT_W-1:0] term_sel;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Terminal count per select: all-ones trimmed to the period's width.
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_term
    assign term[g] = {CNT_W{1'b1}} >> (STEP_LOG2 * (NUM_SEL - 1 - g));
  end

  assign term_sel = term[act_sel];

  always_comb begin
    cnt_d = cnt_q;
    ovf   = 1'b0;
    if (clr_fire) begin
      cnt_d = '0;
    end else if (tick_en) begin
      if (cnt_q == term_sel) begin
        cnt_d = '0;
        ovf   = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/lsw_wdt_stage.sv
module lsw_wdt_stage
  import lsw_wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic clr_fire,
  output logic nmi_req,
  output logic rst_req
);
  wdt_stage_e stage_q, stage_d;
  logic       nmi_q, nmi_d;

  always_comb begin
    stage_d = stage_q;
    nmi_d   = 1'b0;
    case (stage_q)
      STG_IDLE: begin
        if (!clr_fire && ovf) begin
          stage_d = STG_WARNED;
          nmi_d   = 1'b1;
        end
      end
      STG_WARNED: begin
        if (clr_fire)  stage_d = STG_IDLE;
        else if (ovf)  stage_d = STG_TRIPPED;
      end
      STG_TRIPPED: stage_d = STG_TRIPPED;
      default:     stage_d = STG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_IDLE;
      nmi_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      nmi_q   <= nmi_d;
    end
  end

  assign nmi_req = nmi_q;
  assign rst_req = (stage_q == STG_TRIPPED);
endmodule

// File: rtl/lsw_watchdog.sv
module lsw_watchdog
  import lsw_wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2,
  parameter int DATA_W    = 8,
  localparam int NUM_SEL  = 1 << SEL_W,
  localparam int CNT_W    = BASE_LOG2 + STEP_LOG2 * (NUM_SEL - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              nmi_req,
  output logic              rst_req
);
  logic             rst_int_n;
  logic             sel_wr, key_wr, clr_fire, ovf;
  logic [SEL_W-1:0] act_sel;
  logic [CNT_W-1:0] cnt;

  assign sel_wr = wr_en && (wr_addr == ADDR_PERIOD);
  assign key_wr = wr_en && (wr_addr == ADDR_KEY);

  lsw_wdt_rstsync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  lsw_wdt_keyseq #(.KEY_W(DATA_W)) u_key (
    .clk(clk), .rst_n(rst_int_n), .key_wr(key_wr),
    .key_data(wr_data), .clr_fire(clr_fire)
  );

  lsw_wdt_period #(.SEL_W(SEL_W)) u_per (
    .clk(clk), .rst_n(rst_int_n), .sel_wr(sel_wr),
    .sel_data(wr_data[SEL_W-1:0]), .clr_fire(clr_fire), .act_sel(act_sel)
  );

  lsw_wdt_count #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick_en(tick_en), .clr_fire(clr_fire),
    .act_sel(act_sel), .cnt(cnt), .ovf(ovf)
  );

  lsw_wdt_stage u_stg (
    .clk(clk), .rst_n(rst_int_n), .ovf(ovf), .clr_fire(clr_fire),
    .nmi_req(nmi_req), .rst_req(rst_req)
  );
endmodule

// File: rtl/lsw_wdt_chk.sv
module lsw_wdt_chk #(
  parameter int CNT_W = 18,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             clr_fire,
  input logic [CNT_W-1:0] cnt,
  input logic [SEL_W-1:0] act_sel,
  input logic             nmi_req,
  input logic             rst_req
);
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr_fire) |=> $stable(cnt));

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (cnt == '0));

  p_nmi_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  p_rst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  p_tripped_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !nmi_req);

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_fire |=> $stable(act_sel));
endmodule

bind lsw_watchdog lsw_wdt_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .tick_en(tick_en), .clr_fire(clr_fire),
  .cnt(cnt), .act_sel(act_sel), .nmi_req(nmi_req), .rst_req(rst_req)
);

// File: tb/sim_lsw_watchdog.sv
module sim_lsw_watchdog;
  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       nmi_req, rst_req;

  int unsigned cyc = 0;
  int unsigned checks = 0;
  int unsigned fails = 0;
  bit          rst_prev = 1'b0;

  bit          exp_kind[$];
  int unsigned exp_cyc[$];
  string       exp_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lsw_watchdog #(.BASE_LOG2(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .nmi_req(nmi_req), .rst_req(rst_req)
  );

  function automatic int unsigned plen(input int sel);
    return (1 << BASE) << (2 * sel);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(input bit kind, input int unsigned at, input string tag);
    exp_kind.push_back(kind);
    exp_cyc.push_back(at);
    exp_tag.push_back(tag);
  endtask

  task automatic take(input bit kind);
    bit k; int unsigned c; string t;
    checks++;
    if (exp_kind.size() == 0) begin
      fails++;
      $display("FAIL R5/R6/R7: unexpected %s at cycle %0d, expected none",
               kind ? "rst_req" : "nmi_req", cyc);
    end else begin
      k = exp_kind.pop_front(); c = exp_cyc.pop_front(); t = exp_tag.pop_front();
      if (k != kind || c != cyc) begin
        fails++;
        $display("FAIL %s: actual kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                 t, kind, cyc, k, c);
      end
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (nmi_req) take(1'b0);
      if (rst_req && !rst_prev) take(1'b1);
      if (!rst_req && rst_prev) chk(1'b0, "R7 rst_req dropped", 0, 1);
    end
    rst_prev = rst_req;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit a, input logic [7:0] d, output int unsigned e);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    e = cyc;
    wr_en = 1'b0;
  endtask

  task automatic kick(output int unsigned e);
    int unsigned tmp;
    wr(1'b1, 8'h5A, tmp);
    wr(1'b1, 8'hA5, e);
  endtask

  // Returns the edge that acts as the virtual clear after reset release.
  task automatic do_reset(output int unsigned vc);
    rst_n = 1'b0;
    wait_n(2);
    chk(!nmi_req && !rst_req, "R1 outputs in reset", {nmi_req, rst_req}, 0);
    rst_n = 1'b1;
    vc = cyc + 2;
  endtask

  initial begin
    int unsigned vc, e, t;
    wait_n(3);
    chk(!nmi_req && !rst_req, "R1 reset state", {nmi_req, rst_req}, 0);

    // Escalation from reset with default select 0
    do_reset(vc);
    expect_ev(1'b0, vc + plen(0), "R1/R5 first expiry nmi");
    expect_ev(1'b1, vc + 2 * plen(0), "R6 second expiry rst");
    wait_n(40);
    chk(rst_req, "R6 rst_req high", rst_req, 1);
    kick(e);
    wait_n(40);
    chk(rst_req && !nmi_req, "R7 sticky after clear", {rst_req, nmi_req}, 2);

    // Keep-alive, stage return, bad key sequences
    do_reset(vc);
    wait_n(3);
    kick(e);
    for (int i = 0; i < 6; i++) begin
      wait_n(8);
      kick(e);
    end
    expect_ev(1'b0, e + plen(0), "R4 nmi after last keep-alive");
    wait_n(20);
    kick(e);
    expect_ev(1'b0, e + plen(0), "R4 stage back to idle");
    wait_n(20);
    kick(e);
    expect_ev(1'b0, e + plen(0), "R3 bad keys no clear nmi");
    expect_ev(1'b1, e + 2 * plen(0), "R3 bad keys no clear rst");
    wait_n(2);
    wr(1'b1, 8'h5A, t);
    wr(1'b1, 8'h33, t);
    wr(1'b1, 8'hA5, t);
    wr(1'b1, 8'hA5, t);
    wait_n(40);
    chk(rst_req, "R3 rst_req after rejected keys", rst_req, 1);

    // Address decode and key detector corners
    do_reset(vc);
    wait_n(3);
    kick(e);
    wr(1'b0, 8'h5A, t);
    wr(1'b0, 8'hA5, t);
    expect_ev(1'b0, e + plen(0), "R9 keys to period reg ignored");
    wait_n(20);
    wr(1'b1, 8'h5A, t);
    wr(1'b0, 8'h00, t);
    wr(1'b1, 8'hA5, e);
    expect_ev(1'b0, e + plen(0), "R3 period write between keys");
    wait_n(20);
    wr(1'b1, 8'h5A, t);
    wr(1'b1, 8'h5A, t);
    wr(1'b1, 8'hA5, e);
    expect_ev(1'b0, e + plen(0), "R3 repeated unlock stays armed");
    wait_n(20);

    // Deferred period load
    do_reset(vc);
    wait_n(3);
    kick(e);
    wr(1'b0, 8'h01, t);
    expect_ev(1'b0, e + plen(0), "R8 old period until clear");
    wait_n(20);
    kick(e);
    expect_ev(1'b0, e + plen(1), "R2/R8 select 1 nmi");
    expect_ev(1'b1, e + 2 * plen(1), "R6 select 1 rst");
    wait_n(135);

    // Longest period
    do_reset(vc);
    wait_n(3);
    wr(1'b0, 8'h03, t);
    kick(e);
    expect_ev(1'b0, e + plen(3), "R2 select 3 nmi");
    expect_ev(1'b1, e + 2 * plen(3), "R2 select 3 rst");
    wait_n(2 * plen(3) + 8);

    // Tick gap with select 2
    do_reset(vc);
    wait_n(3);
    wr(1'b0, 8'h02, t);
    kick(e);
    tick_en = 1'b0;
    wait_n(50);
    tick_en = 1'b1;
    expect_ev(1'b0, e + 50 + plen(2), "R2 count pauses without tick");
    wait_n(plen(2) + 10);
    kick(e);
    wait_n(5);

    chk(exp_kind.size() == 0, "R5/R6 missing events", exp_kind.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule